// File: doc/BRIEF.md
# Raster Display Controller with Per-Channel Gamma

The block drives a progressive raster display from a single pixel clock. Free-running horizontal and vertical counters produce the two sync pulses and a visible-area window. The default timing is 640x480 at 60 Hz from a 25 MHz clock. Inside the window the block pulls one 32-bit word per pixel from a show-ahead prefetch FIFO and splits it into red, green and blue bytes, dropping the spare byte. Each byte indexes its own 256-entry gamma table. The corrected colour leaves the block two clocks after the counter position that produced it, and the sync outputs are delayed by the same two clocks so that the two stay aligned.

The gamma tables come up as identity curves at reset. A write port can reload any entry while the raster runs, because the right curve depends on the attached display and is found by measurement. If the FIFO runs dry inside the visible window, the pixel is shown black and a sticky flag records the event. Outside the window the colour outputs are held at zero.

Top module: `raster_gamma_ctrl`

## Requirements
- R1: Counting pixel clocks from the start of a line (position 0), `hsync_n` is low for H_PULSE clocks starting at position H_ACTIVE+H_FRONT. A line lasts H_ACTIVE+H_FRONT+H_PULSE+H_BACK clocks.
- R2: Counting lines from the start of a frame, `vsync_n` is low for V_PULSE whole lines starting at line V_ACTIVE+V_FRONT. It changes only at a line start. A frame lasts V_ACTIVE+V_FRONT+V_PULSE+V_BACK lines.
- R3: `fifo_pop` is high in exactly those cycles where the current position lies in the visible window (position < H_ACTIVE and line < V_ACTIVE) and `fifo_empty` is low.
- R4: A popped word is split as red = bits 31:24, green = bits 23:16, blue = bits 15:8. Bits 7:0 have no effect on any output.
- R5: Each channel's byte is replaced by its own table entry at that byte's address. After reset every table holds identity (entry i = i).
- R6: A write with `cfg_we` high stores `cfg_data` at `cfg_addr` in the table chosen by `cfg_sel` (0 red, 1 green, 2 blue). Select value 3 changes no table.
- R7: When a write and a lookup hit the same entry in the same cycle, that lookup returns the old value and later lookups return the new one.
- R8: `red`, `green` and `blue` are zero for every position outside the visible window.
- R9: Sync levels and colour for a given counter position appear at the outputs two clock cycles after that position is current.
- R10: A visible position met with `fifo_empty` high pops nothing and shows black. It sets `underflow` from the next cycle on, and the flag stays set until reset. An empty FIFO outside the window never sets the flag.
- R11: While `rst_n` is low, both syncs are high, the colours are zero and `underflow` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | input | 32 | Head word of the prefetch FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word this cycle |
| cfg_we | input | 1 | Gamma table write strobe |
| cfg_sel | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| cfg_addr | input | 8 | Table entry address |
| cfg_data | input | 8 | Value to store |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 8 | Corrected red |
| green | output | 8 | Corrected green |
| blue | output | 8 | Corrected blue |
| underflow | output | 1 | Sticky: FIFO ran dry inside the visible window |

## Verification
A table write from the configuration port and a pixel lookup of the same entry can land on the same clock edge, and which value the pixel receives follows from the ordering rule in R7. The bench feeds a constant word so that every pixel reads one entry. It issues the write in the cycle before an edge at which a visible pixel sits in the lookup stage and the next position is also visible. It then expects the old value right after that edge and the new value one cycle later. A second overlap is between FIFO starvation and blanking. The bench holds the FIFO empty exactly over the blanking intervals and expects the flag to stay clear, then starves it inside the window and expects black pixels and a flag that stays set.

// File: rtl/raster_pkg.sv
package raster_pkg;

   localparam int CH_W   = 8;
   localparam int WORD_W = 32;

   typedef struct packed {
      logic [CH_W-1:0] r;
      logic [CH_W-1:0] g;
      logic [CH_W-1:0] b;
   } rgb_t;

   typedef enum logic [1:0] {
      SEL_RED  = 2'd0,
      SEL_GRN  = 2'd1,
      SEL_BLU  = 2'd2,
      SEL_NONE = 2'd3
   } tbl_sel_e;

   function automatic rgb_t split_word(input logic [WORD_W-1:0] w);
      rgb_t p;
      p.r = w[31:24];
      p.g = w[23:16];
      p.b = w[15:8];
      return p;
   endfunction

endpackage

// File: rtl/raster_timing.sv
module raster_timing #(
   parameter int H_ACTIVE = 640,
   parameter int H_FRONT  = 16,
   parameter int H_PULSE  = 96,
   parameter int H_BACK   = 48,
   parameter int V_ACTIVE = 480,
   parameter int V_FRONT  = 10,
   parameter int V_PULSE  = 2,
   parameter int V_BACK   = 33
) (
   input  logic clk,
   input  logic rst_n,
   output logic vis,
   output logic hs_act,
   output logic vs_act
);
   localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_PULSE + H_BACK;
   localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_PULSE + V_BACK;
   localparam int HW       = $clog2(H_TOTAL);
   localparam int VW       = $clog2(V_TOTAL);
   localparam int HS_BEG   = H_ACTIVE + H_FRONT;
   localparam int HS_END   = HS_BEG + H_PULSE;
   localparam int VS_BEG   = V_ACTIVE + V_FRONT;
   localparam int VS_END   = VS_BEG + V_PULSE;

   if (H_ACTIVE < 1 || H_PULSE < 1 || H_FRONT < 0 || H_BACK < 0) begin : g_bad_h
      $error("raster_timing: illegal horizontal timing");
   end
   if (V_ACTIVE < 1 || V_PULSE < 1 || V_FRONT < 0 || V_BACK < 0) begin : g_bad_v
      $error("raster_timing: illegal vertical timing");
   end

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          line_end;
   logic          frame_end;

   assign line_end  = (hcnt == HW'(H_TOTAL - 1));
   assign frame_end = (vcnt == VW'(V_TOTAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (line_end) begin
         hcnt <= '0;
         vcnt <= frame_end ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_comb begin
      vis    = (hcnt < HW'(H_ACTIVE)) && (vcnt < VW'(V_ACTIVE));
      hs_act = (hcnt >= HW'(HS_BEG)) && (hcnt < HW'(HS_END));
      vs_act = (vcnt >= VW'(VS_BEG)) && (vcnt < VW'(VS_END));
   end

   // R1
   hsync_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_act |-> !vis);

   // R2
   vsync_line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_act != $past(vs_act)) |-> (hcnt == '0));

endmodule

// File: rtl/raster_fetch.sv
module raster_fetch
   import raster_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vis,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              fifo_pop,
   output rgb_t              pix,
   output logic              blank,
   output logic              underflow
);
   logic starve;
   logic unused_pad;

   assign fifo_pop   = vis && !fifo_empty;
   assign starve     = vis && fifo_empty;
   assign unused_pad = ^fifo_data[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix       <= '0;
         blank     <= 1'b1;
         underflow <= 1'b0;
      end else begin
         pix   <= fifo_pop ? split_word(fifo_data) : '0;
         blank <= !fifo_pop;
         if (starve) underflow <= 1'b1;
      end
   end

   // R10
   underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   // R10
   starve_goes_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vis && fifo_empty) |=> (blank && underflow));

endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
   import raster_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int OUT_W = 8,
   parameter int N_CH  = 3,
   parameter int SEL_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [SEL_W-1:0]        sel,
   input  logic [IDX_W-1:0]        waddr,
   input  logic [OUT_W-1:0]        wdata,
   input  logic [N_CH*IDX_W-1:0]   idx,
   input  logic                    blank,
   output logic [N_CH*OUT_W-1:0]   q
);
   localparam int DEPTH = 1 << IDX_W;

   if (N_CH > int'(SEL_NONE) || N_CH >= (1 << SEL_W)) begin : g_bad_ch
      $error("gamma_lut: a select code must stay free for no-op writes");
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [OUT_W-1:0] mem [DEPTH];
      logic             hit;

      assign hit = we && (sel == SEL_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= OUT_W'(i);
            q[c*OUT_W +: OUT_W] <= '0;
         end else begin
            if (hit) mem[waddr] <= wdata;
            q[c*OUT_W +: OUT_W] <= blank ? '0 : mem[idx[c*IDX_W +: IDX_W]];
         end
      end

      // R8
      blank_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         blank |=> (q[c*OUT_W +: OUT_W] == '0));
   end

endmodule

// File: rtl/raster_gamma_ctrl.sv
module raster_gamma_ctrl
   import raster_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int H_FRONT  = 16,
   parameter int H_PULSE  = 96,
   parameter int H_BACK   = 48,
   parameter int V_ACTIVE = 480,
   parameter int V_FRONT  = 10,
   parameter int V_PULSE  = 2,
   parameter int V_BACK   = 33,
   parameter bit SYNC_LOW = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] fifo_data,
   input  logic        fifo_empty,
   output logic        fifo_pop,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [7:0]  cfg_addr,
   input  logic [7:0]  cfg_data,
   output logic        hsync_n,
   output logic        vsync_n,
   output logic [7:0]  red,
   output logic [7:0]  green,
   output logic [7:0]  blue,
   output logic        underflow
);
   localparam int   PIPE    = 2;
   localparam logic ACT_LVL = SYNC_LOW ? 1'b0 : 1'b1;

   logic            vis, hs_act, vs_act;
   rgb_t            pix;
   logic            blank;
   logic [3*CH_W-1:0] lut_q;
   logic [PIPE-1:0] hs_pipe, vs_pipe;

   raster_timing #(
      .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_PULSE(H_PULSE), .H_BACK(H_BACK),
      .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_PULSE(V_PULSE), .V_BACK(V_BACK)
   ) u_timing (
      .clk    (clk),
      .rst_n  (rst_n),
      .vis    (vis),
      .hs_act (hs_act),
      .vs_act (vs_act)
   );

   raster_fetch u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .vis        (vis),
      .fifo_data  (fifo_data),
      .fifo_empty (fifo_empty),
      .fifo_pop   (fifo_pop),
      .pix        (pix),
      .blank      (blank),
      .underflow  (underflow)
   );

   gamma_lut #(.IDX_W(CH_W), .OUT_W(CH_W), .N_CH(3), .SEL_W(2)) u_lut (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_sel),
      .waddr (cfg_addr),
      .wdata (cfg_data),
      .idx   ({pix.b, pix.g, pix.r}),
      .blank (blank),
      .q     (lut_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_pipe <= {PIPE{!ACT_LVL}};
         vs_pipe <= {PIPE{!ACT_LVL}};
      end else begin
         hs_pipe <= {hs_pipe[PIPE-2:0], hs_act ? ACT_LVL : !ACT_LVL};
         vs_pipe <= {vs_pipe[PIPE-2:0], vs_act ? ACT_LVL : !ACT_LVL};
      end
   end

   assign hsync_n = hs_pipe[PIPE-1];
   assign vsync_n = vs_pipe[PIPE-1];
   assign red     = lut_q[0*CH_W +: CH_W];
   assign green   = lut_q[1*CH_W +: CH_W];
   assign blue    = lut_q[2*CH_W +: CH_W];

   // R9
   hsync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_n == ($past(hs_act, 2) ? ACT_LVL : !ACT_LVL));

   // R9
   vsync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_n == ($past(vs_act, 2) ? ACT_LVL : !ACT_LVL));

   // R8
   offscreen_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(vis, 2) |-> ({red, green, blue} == '0));

endmodule

// File: tb/raster_gamma_ctrl_test.sv
module raster_gamma_ctrl_test;
   localparam int HA = 8, HF = 2, HP = 3, HB = 2;
   localparam int VA = 4, VF = 1, VP = 2, VB = 1;
   localparam int HT = HA + HF + HP + HB;
   localparam int VT = VA + VF + VP + VB;
   localparam int FRAME = HT * VT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fifo_data;
   logic        fifo_empty = 1'b1;
   logic        fifo_pop;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [7:0]  cfg_addr = 8'd0;
   logic [7:0]  cfg_data = 8'd0;
   logic        hsync_n, vsync_n, underflow;
   logic [7:0]  red, green, blue;

   always #10 clk = ~clk;

   raster_gamma_ctrl #(
      .H_ACTIVE(HA), .H_FRONT(HF), .H_PULSE(HP), .H_BACK(HB),
      .V_ACTIVE(VA), .V_FRONT(VF), .V_PULSE(VP), .V_BACK(VB), .SYNC_LOW(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
      .fifo_pop(fifo_pop), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red),
      .green(green), .blue(blue), .underflow(underflow)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   bit chk_en = 0;

   // stimulus source
   int         rd_idx = 0;
   int         mode = 0;
   logic [7:0] cr = 8'h00, cg = 8'h00, cb = 8'h00;

   function automatic logic [31:0] make_word(int k, int m, logic [7:0] a, logic [7:0] b, logic [7:0] c);
      logic [7:0] x;
      x = k[7:0];
      if (m == 0) return {x, x + 8'd85, ~x, x ^ 8'h3C};
      return {a, b, c, x * 8'd7};
   endfunction

   assign fifo_data = make_word(rd_idx, mode, cr, cg, cb);

   // reference model built from the requirements
   int         mh = 0, mv = 0;
   bit         s1_hs = 1, s1_vs = 1, s1_vis = 0, s1_blk = 1;
   logic [7:0] s1_r = 0, s1_g = 0, s1_b = 0;
   bit         e_hs = 1, e_vs = 1, e_vis = 0, e_blk = 1, e_under = 0;
   logic [23:0] e_rgb = 0;
   logic [7:0] gr [256];
   logic [7:0] gg [256];
   logic [7:0] gb [256];
   bit         m_vis, m_pop;

   function automatic bit in_window(int h, int v);
      return (h < HA) && (v < VA);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mh = 0; mv = 0;
         s1_hs = 1; s1_vs = 1; s1_vis = 0; s1_blk = 1;
         s1_r = 0; s1_g = 0; s1_b = 0;
         e_hs = 1; e_vs = 1; e_vis = 0; e_blk = 1; e_under = 0; e_rgb = 0;
         for (int i = 0; i < 256; i++) begin
            gr[i] = i[7:0]; gg[i] = i[7:0]; gb[i] = i[7:0];
         end
         rd_idx <= 0;
      end else begin
         e_hs = s1_hs; e_vs = s1_vs; e_vis = s1_vis; e_blk = s1_blk;
         e_rgb = s1_blk ? 24'h0 : {gb[s1_b], gg[s1_g], gr[s1_r]};
         if (cfg_we) begin
            case (cfg_sel)
               2'd0: gr[cfg_addr] = cfg_data;
               2'd1: gg[cfg_addr] = cfg_data;
               2'd2: gb[cfg_addr] = cfg_data;
               default: ;
            endcase
         end
         m_vis = in_window(mh, mv);
         m_pop = m_vis && !fifo_empty;
         s1_hs = !(mh >= HA + HF && mh < HA + HF + HP);
         s1_vs = !(mv >= VA + VF && mv < VA + VF + VP);
         s1_vis = m_vis;
         s1_blk = !m_pop;
         s1_r = fifo_data[31:24]; s1_g = fifo_data[23:16]; s1_b = fifo_data[15:8];
         if (m_vis && fifo_empty) e_under = 1;
         if (m_pop) rd_idx <= rd_idx + 1;
         if (mh == HT - 1) begin
            mh = 0;
            mv = (mv == VT - 1) ? 0 : mv + 1;
         end else begin
            mh = mh + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, sampled after the falling edge
   always @(negedge clk) begin
      if (chk_en && !done) begin
         #2;
         check("R1 R9 hsync", {31'd0, hsync_n}, {31'd0, e_hs});
         check("R2 R9 vsync", {31'd0, vsync_n}, {31'd0, e_vs});
         check("R3 pop", {31'd0, fifo_pop}, {31'd0, in_window(mh, mv) && !fifo_empty});
         if (e_vis) check("R4 R5 R9 colour", {8'd0, blue, green, red}, {8'd0, e_rgb});
         else       check("R8 offscreen colour", {8'd0, blue, green, red}, 32'd0);
         check("R10 underflow flag", {31'd0, underflow}, {31'd0, e_under});
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_lit_pixel();
      for (int g = 0; g < 4 * FRAME; g++) begin
         @(negedge clk);
         #3;
         if (e_vis && !e_blk) break;
      end
   endtask

   task automatic tbl_write(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      cycles(4);
      #3;
      check("R11 reset hsync", {31'd0, hsync_n}, 32'd1);
      check("R11 reset vsync", {31'd0, vsync_n}, 32'd1);
      check("R11 reset colour", {8'd0, blue, green, red}, 32'd0);
      check("R11 reset underflow", {31'd0, underflow}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      chk_en = 1'b1;
   endtask

   task automatic t_identity();
      mode = 0;
      fifo_empty = 1'b0;
      cycles(2 * FRAME);
      for (int g = 0; g < FRAME; g++) begin
         @(negedge clk);
         #3;
         if (!e_vis) break;
      end
      check("R8 blanking with data present", {8'd0, blue, green, red}, 32'd0);
   endtask

   task automatic t_dummy_byte();
      mode = 1; cr = 8'h12; cg = 8'h34; cb = 8'h56;
      cycles(FRAME);
      wait_lit_pixel();
      check("R4 unpack ignores low byte", {8'd0, red, green, blue}, 32'h00123456);
      @(negedge clk); #3;
      check("R4 R5 identity next pixel", {8'd0, red, green, blue}, 32'h00123456);
   endtask

   task automatic t_program();
      for (int i = 0; i < 256; i++) begin
         tbl_write(2'd0, i[7:0], ~i[7:0]);
         tbl_write(2'd1, i[7:0], i[8:1]);
         tbl_write(2'd2, i[7:0], 8'((i * i) >> 8));
      end
      tbl_write(2'd3, 8'h10, 8'h00);
      tbl_write(2'd3, 8'h80, 8'h00);
      tbl_write(2'd3, 8'hF0, 8'h00);
      mode = 1; cr = 8'h10; cg = 8'h80; cb = 8'hF0;
      cycles(FRAME);
      wait_lit_pixel();
      check("R6 red table", {24'd0, red}, 32'h000000EF);
      check("R6 green table", {24'd0, green}, 32'h00000040);
      check("R6 blue table, select 3 ignored", {24'd0, blue}, 32'h000000E1);
   endtask

   task automatic t_same_cycle();
      logic [7:0] old_v, new_v;
      mode = 1; cr = 8'h40; cg = 8'h00; cb = 8'h00;
      fifo_empty = 1'b0;
      cycles(FRAME);
      for (int g = 0; g < 4 * FRAME; g++) begin
         @(negedge clk);
         #1;
         if (!s1_blk && in_window(mh, mv)) break;
      end
      old_v = gr[8'h40];
      new_v = old_v ^ 8'hFF;
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = 8'h40; cfg_data = new_v;
      @(negedge clk);
      cfg_we = 1'b0;
      #2;
      check("R7 lookup in write cycle sees old", {24'd0, red}, {24'd0, old_v});
      @(negedge clk);
      #2;
      check("R7 following lookup sees new", {24'd0, red}, {24'd0, new_v});
   endtask

   task automatic t_blank_starve();
      mode = 0;
      for (int g = 0; g < 2 * FRAME; g++) begin
         @(negedge clk);
         fifo_empty = !in_window(mh, mv);
      end
      @(negedge clk);
      fifo_empty = 1'b0;
      #3;
      check("R10 empty in blanking leaves flag clear", {31'd0, underflow}, 32'd0);
   endtask

   task automatic t_visible_starve();
      fifo_empty = 1'b1;
      cycles(2 * HT);
      #3;
      check("R10 starvation sets flag", {31'd0, underflow}, 32'd1);
      @(negedge clk);
      fifo_empty = 1'b0;
      cycles(2 * FRAME);
      #3;
      check("R10 flag stays set", {31'd0, underflow}, 32'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      finish_run();
   end

   initial begin
      t_reset();
      t_identity();
      t_dummy_byte();
      t_program();
      t_same_cycle();
      t_blank_starve();
      t_visible_starve();
      cycles(4);
      finish_run();
   end

endmodule